// File: doc/BRIEF.md
# TDM Time Slot Interchange

This block is the switching core of a time-division multiplexed switch. It has eight serial input lanes and eight serial output lanes. Each lane carries a frame of 32 channels of 8 bits, sent most significant bit first. Every received channel is stored in a data memory. Every output channel is then filled either from a stored input channel, which gives a full 256 x 256 non-blocking crossbar, or from a fixed byte that the control processor has written. The processor programs the switch through two per-output-channel tables, routing and control, one write port each.

Bit clock recovery and frame pulse detection are done outside the block. They arrive as a one-cycle bit strobe and a frame-sync flag. Routing entries can pick, channel by channel, between two delay modes. The lowest-delay mode uses the freshest copy of the source. The fixed-delay mode always reads the copy from two frames back, which keeps groups of channels in step. A three-bank data memory holds the copies. The block also produces per-channel output enables, a global output kill and a serial control-bit stream that runs one channel ahead of the data lanes.

Top module: `tdm_slot_switch`

## Requirements
- R1: Each `bit_en` pulse ends one bit time. Eight bit times form a channel, and 32 channels form a frame. The first bit of a channel is bit 7. `frame_sync`, asserted with the `bit_en` that ends the last bit of a frame, starts channel 0 of the next frame. Counting starts at frame 0, channel 0, bit 7 after reset.
- R2: When an output channel is in connection mode, it carries the stored byte selected by its routing entry. Routing entry bits 7:5 give the source lane and bits 4:0 give the source channel. Several outputs may name the same source.
- R3: Control-entry bit 2 set puts the output channel in message mode. It then emits all 8 bits of its routing entry in every frame, until that entry is rewritten.
- R4: Control-entry bit 6 clear selects minimum delay. Let d = (m - n) mod 32, for source channel n and output channel m. When d >= 3, the output carries the source byte d slots later. Otherwise it carries the byte d + 32 slots later.
- R5: Control-entry bit 6 set selects fixed delay. A source byte received in frame f appears on its output channel in frame f + 2.
- R6: Control-entry bit 0 is the output enable. When it is 0, `ser_out_en` stays low for that lane and channel. The table resets to all zeros.
- R7: `msg_all` high makes every output channel behave as if control bits 2 and 0 were both set.
- R8: `drive_en` low forces every `ser_out_en` bit low, whatever the table and `msg_all` say.
- R9: During the bit time at position p (p = 0 for bit 7) of channel c, `ctl_bit` carries control bit 1 of lane p, channel (c + 1) mod 32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_en | input | 1 | Bit strobe; input bits are sampled and a bit time ends here |
| frame_sync | input | 1 | Frame boundary, valid together with bit_en |
| ser_in | input | 8 | One serial input bit per lane |
| ser_out | output | 8 | One serial output bit per lane |
| ser_out_en | output | 8 | Drive enable per lane (low = high impedance) |
| ctl_bit | output | 1 | Serial control-bit stream |
| drive_en | input | 1 | Global output drive enable |
| msg_all | input | 1 | Force every channel to message mode and enabled |
| cm_we_lo | input | 1 | Write strobe for the routing table |
| cm_we_hi | input | 1 | Write strobe for the control table (bits 6, 2, 1, 0 kept) |
| cm_addr | input | 8 | Table address: lane in bits 7:5, channel in bits 4:0 |
| cm_wdata | input | 8 | Table write data |

## Verification
The assertions check three things on every cycle. Fixed-delay fetches never touch the bank being filled. A current-bank fetch only reads a source channel that has already been written. `drive_en` low leaves no lane enabled, and the lanes and the control stream hold steady between bit strobes. Only the bench scenarios can show the rest: the delay rule (same-frame, next-frame and two-frame cases, including wrap at channel 31), broadcast, a message byte being replaced, the global message override and the control-bit stream mapping. Each of these depends on what happened frames earlier.

// File: rtl/tsi_pkg.sv
package tsi_pkg;
  parameter int STREAMS = 8;
  parameter int CHANS   = 32;
  parameter int BW      = 8;
  localparam int SW   = $clog2(STREAMS);
  localparam int CW   = $clog2(CHANS);
  localparam int BPW  = $clog2(BW);
  localparam int AW   = SW + CW;
  localparam int NENT = STREAMS * CHANS;
  localparam int NDM  = 4 * NENT;   // bank index is 2 bits, three banks used

  typedef struct packed {
    logic cdly;   // fixed two-frame delay
    logic msg;    // message mode
    logic cst;    // control stream bit
    logic oe;     // output enable
  } ctl_t;

  // (b - k) modulo 3 for k in 0..2
  function automatic logic [1:0] bank_back(input logic [1:0] b, input logic [1:0] k);
    logic [2:0] t;
    t = {1'b0, b} + 3'd3 - {1'b0, k};
    if (t >= 3'd3) t = t - 3'd3;
    return t[1:0];
  endfunction

  // frames to look back for minimum-delay mode: wrap plus short-gap penalty
  function automatic logic [1:0] var_lag(input logic [CW-1:0] m, input logic [CW-1:0] n);
    logic [CW-1:0] d;
    d = m - n;
    return {1'b0, (m < n)} + {1'b0, (d < CW'(3))};
  endfunction
endpackage

// File: rtl/tsi_timing.sv
module tsi_timing
  import tsi_pkg::*;
(
  input  logic           clk,
  input  logic           rst_n,
  input  logic           bit_en,
  input  logic           frame_sync,
  output logic [BPW-1:0] bpos,
  output logic [CW-1:0]  chan,
  output logic [1:0]     frm,
  output logic           chan_end,
  output logic           frame_end
);
  assign chan_end  = bit_en && (bpos == BPW'(BW - 1));
  assign frame_end = bit_en && (frame_sync || (chan_end && chan == CW'(CHANS - 1)));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bpos <= '0;
      chan <= '0;
      frm  <= '0;
    end else if (bit_en) begin
      if (frame_end) begin
        bpos <= '0;
        chan <= '0;
        frm  <= (frm == 2'd2) ? 2'd0 : frm + 2'd1;
      end else if (chan_end) begin
        bpos <= '0;
        chan <= chan + 1'b1;
      end else begin
        bpos <= bpos + 1'b1;
      end
    end
  end

  a_r1_bank_range: assert property (@(posedge clk) disable iff (!rst_n) frm != 2'd3);
  a_r1_chan_step: assert property (@(posedge clk) disable iff (!rst_n)
    (chan_end && !frame_end) |=> chan == $past(chan) + 1'b1);
endmodule

// File: rtl/tsi_rx.sv
module tsi_rx
  import tsi_pkg::*;
#(
  parameter int NS = STREAMS
)(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  bit_en,
  input  logic [NS-1:0]         si,
  output logic [NS-1:0][BW-1:0] rx_byte
);
  for (genvar s = 0; s < NS; s++) begin : g_lane
    logic [BW-2:0] sh;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      sh <= '0;
      else if (bit_en) sh <= {sh[BW-3:0], si[s]};
    end
    assign rx_byte[s] = {sh, si[s]};
  end
endmodule

// File: rtl/tsi_tx.sv
module tsi_tx
  import tsi_pkg::*;
#(
  parameter int NS = STREAMS
)(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  bit_en,
  input  logic                  load,
  input  logic [NS-1:0][BW-1:0] ld_byte,
  input  logic [NS-1:0]         ld_oe,
  input  logic                  drive_en,
  output logic [NS-1:0]         so_d,
  output logic [NS-1:0]         so_oe
);
  for (genvar s = 0; s < NS; s++) begin : g_lane
    logic [BW-1:0] sh;
    logic          oe_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        sh   <= '0;
        oe_q <= 1'b0;
      end else if (load) begin
        sh   <= ld_byte[s];
        oe_q <= ld_oe[s];
      end else if (bit_en) begin
        sh   <= {sh[BW-2:0], 1'b0};
      end
    end
    assign so_d[s]  = sh[BW-1];
    assign so_oe[s] = oe_q & drive_en;
  end

  a_r1_out_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_en |=> $stable(so_d));
endmodule

// File: rtl/tdm_slot_switch.sv
module tdm_slot_switch
  import tsi_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bit_en,
  input  logic               frame_sync,
  input  logic [STREAMS-1:0] ser_in,
  output logic [STREAMS-1:0] ser_out,
  output logic [STREAMS-1:0] ser_out_en,
  output logic               ctl_bit,
  input  logic               drive_en,
  input  logic               msg_all,
  input  logic               cm_we_lo,
  input  logic               cm_we_hi,
  input  logic [AW-1:0]      cm_addr,
  input  logic [BW-1:0]      cm_wdata
);
  logic [BPW-1:0] bpos;
  logic [CW-1:0]  chan;
  logic [1:0]     frm;
  logic           chan_end, frame_end;

  tsi_timing u_tim (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .frame_sync(frame_sync),
    .bpos(bpos), .chan(chan), .frm(frm), .chan_end(chan_end), .frame_end(frame_end)
  );

  logic [STREAMS-1:0][BW-1:0] rx_byte;
  tsi_rx #(.NS(STREAMS)) u_rx (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .si(ser_in), .rx_byte(rx_byte)
  );

  // per-output-channel tables
  logic [BW-1:0] cml [NENT];
  ctl_t          cmh [NENT];

  always_ff @(posedge clk) begin
    if (cm_we_lo) cml[cm_addr] <= cm_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NENT; i++) cmh[i] <= '0;
    end else if (cm_we_hi) begin
      cmh[cm_addr] <= '{cdly: cm_wdata[6], msg: cm_wdata[2], cst: cm_wdata[1], oe: cm_wdata[0]};
    end
  end

  // three-bank data memory, indexed {bank, lane, channel}
  logic [BW-1:0] dmem [NDM];
  always_ff @(posedge clk) begin
    if (chan_end) begin
      for (int s = 0; s < STREAMS; s++) dmem[{frm, SW'(s), chan}] <= rx_byte[s];
    end
  end

  // fetch for the next output channel happens at the end of the current one
  logic [CW-1:0] fetch_chan;
  logic [1:0]    fetch_bank;
  assign fetch_chan = frame_end ? '0 : chan + 1'b1;
  assign fetch_bank = frame_end ? ((frm == 2'd2) ? 2'd0 : frm + 2'd1) : frm;

  logic [STREAMS-1:0][BW-1:0] ld_byte;
  logic [STREAMS-1:0]         ld_oe;
  logic [STREAMS-1:0]         cdly_sel;
  logic [STREAMS-1:0][1:0]    rd_bank;
  logic [STREAMS-1:0][CW-1:0] src_chan;

  always_comb begin
    logic [AW-1:0] idx;
    ctl_t          c;
    logic [BW-1:0] lo;
    logic [1:0]    lag;
    for (int s = 0; s < STREAMS; s++) begin
      idx         = {SW'(s), fetch_chan};
      c           = cmh[idx];
      lo          = cml[idx];
      lag         = c.cdly ? 2'd2 : var_lag(fetch_chan, lo[CW-1:0]);
      cdly_sel[s] = c.cdly;
      src_chan[s] = lo[CW-1:0];
      rd_bank[s]  = bank_back(fetch_bank, lag);
      ld_oe[s]    = c.oe | msg_all;
      ld_byte[s]  = (c.msg | msg_all) ? lo : dmem[{rd_bank[s], lo}];
    end
  end

  tsi_tx #(.NS(STREAMS)) u_tx (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .load(chan_end | frame_end),
    .ld_byte(ld_byte), .ld_oe(ld_oe), .drive_en(drive_en),
    .so_d(ser_out), .so_oe(ser_out_en)
  );

  // control stream: lane index = bit position, one channel ahead
  logic [CW-1:0] cst_chan;
  assign cst_chan = chan + 1'b1;
  assign ctl_bit  = cmh[{bpos[SW-1:0], cst_chan}].cst;

  for (genvar s = 0; s < STREAMS; s++) begin : g_chk
    a_r5_const_bank: assert property (@(posedge clk) disable iff (!rst_n)
      (chan_end && cdly_sel[s]) |-> rd_bank[s] != frm);
    a_r4_src_written: assert property (@(posedge clk) disable iff (!rst_n)
      (chan_end && rd_bank[s] == frm) |-> src_chan[s] < chan);
  end

  a_r8_drive_off: assert property (@(posedge clk) disable iff (!rst_n)
    !drive_en |-> ser_out_en == '0);
  a_r9_ctl_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!bit_en && !cm_we_hi) |=> $stable(ctl_bit));
endmodule

// File: tb/tdm_slot_switch_tb.sv
`timescale 1ns/1ps
module tdm_slot_switch_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bit_en = 1'b0;
  logic       frame_sync = 1'b0;
  logic [7:0] ser_in = '0;
  logic [7:0] ser_out, ser_out_en;
  logic       ctl_bit;
  logic       drive_en = 1'b1;
  logic       msg_all = 1'b0;
  logic       cm_we_lo = 1'b0, cm_we_hi = 1'b0;
  logic [7:0] cm_addr = '0, cm_wdata = '0;

  always #2 clk = ~clk;

  tdm_slot_switch dut_i (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .frame_sync(frame_sync),
    .ser_in(ser_in), .ser_out(ser_out), .ser_out_en(ser_out_en), .ctl_bit(ctl_bit),
    .drive_en(drive_en), .msg_all(msg_all), .cm_we_lo(cm_we_lo), .cm_we_hi(cm_we_hi),
    .cm_addr(cm_addr), .cm_wdata(cm_wdata)
  );

  int n_checks = 0;
  int n_fail = 0;
  int tbit = 0;
  bit done = 0;

  // scoreboard queues (kept in time order)
  int    qk[$];
  int    qkind[$];
  int    qs[$];
  bit    qoe[$];
  int    qv[$];
  string qt[$];

  logic [7:0] acc [8];

  function automatic logic [7:0] pat(int f, int s, int n);
    logic [7:0] x;
    x = 8'((s << 5) | n);
    return x ^ 8'(f * 91);
  endfunction

  task automatic expect_item(int f, int n, int p, int kind, int s, bit oe, int v, string tag);
    qk.push_back(f * 256 + n * 8 + p);
    qkind.push_back(kind);
    qs.push_back(s);
    qoe.push_back(oe);
    qv.push_back(v);
    qt.push_back(tag);
  endtask

  task automatic check(bit ok, string tag, int act, int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic monitor_bit();
    int key;
    int p;
    key = tbit;
    p = tbit % 8;
    for (int s = 0; s < 8; s++) acc[s] = {acc[s][6:0], ser_out[s]};
    while (qk.size() > 0 && qk[0] <= key) begin
      if (qk[0] < key) begin
        check(1'b0, {qt[0], " missed slot"}, key, qk[0]);
      end else if (qkind[0] == 1) begin
        check(ctl_bit == qv[0][0], qt[0], int'(ctl_bit), qv[0]);
      end else if (!qoe[0]) begin
        check(ser_out_en[qs[0]] == 1'b0, qt[0], int'(ser_out_en[qs[0]]), 0);
      end else begin
        check(ser_out_en[qs[0]] == 1'b1, {qt[0], " enable"}, int'(ser_out_en[qs[0]]), 1);
        check(acc[qs[0]] == qv[0][7:0], qt[0], int'(acc[qs[0]]), qv[0]);
      end
      void'(qk.pop_front()); void'(qkind.pop_front()); void'(qs.pop_front());
      void'(qoe.pop_front()); void'(qv.pop_front()); void'(qt.pop_front());
    end
    if (p == 7) begin end
  endtask

  task automatic drive_bit();
    int f, n, p;
    logic [7:0] b;
    f = tbit / 256;
    n = (tbit / 8) % 32;
    p = tbit % 8;
    @(negedge clk);
    for (int s = 0; s < 8; s++) begin
      b = pat(f, s, n);
      ser_in[s] = b[7 - p];
    end
    frame_sync = (tbit % 256 == 255);
    bit_en = 1'b1;
    @(negedge clk);
    bit_en = 1'b0;
    frame_sync = 1'b0;
    tbit++;
    monitor_bit();
  endtask

  task automatic run_frame();
    for (int i = 0; i < 256; i++) drive_bit();
  endtask

  task automatic cm_write(bit hi, int s, int n, int v);
    @(negedge clk);
    cm_addr = 8'((s << 5) | n);
    cm_wdata = 8'(v);
    cm_we_hi = hi;
    cm_we_lo = !hi;
    @(negedge clk);
    cm_we_hi = 1'b0;
    cm_we_lo = 1'b0;
  endtask

  task automatic route(int s, int n, int lo, int hi);
    cm_write(1'b0, s, n, lo);
    cm_write(1'b1, s, n, hi);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog (R1) actual=timeout expected=completion");
      summary();
      $finish;
    end
  end

  initial begin
    for (int s = 0; s < 8; s++) acc[s] = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // reset state: control table clear, nothing driven (R6, R9)
    check(ser_out_en == 8'h00, "R6 reset enables", int'(ser_out_en), 0);
    check(ctl_bit == 1'b0, "R9 reset control bit", int'(ctl_bit), 0);

    route(0, 1, 8'h40, 8'h01);  // from lane2 ch0, minimum delay
    route(1, 2, 8'h3E, 8'h01);  // from lane1 ch30
    route(1, 1, 8'h3F, 8'h01);  // from lane1 ch31
    route(2, 3, 8'h00, 8'h01);  // from lane0 ch0
    route(2, 7, 8'h03, 8'h41);  // fixed delay from lane0 ch3
    route(2, 0, 8'hBF, 8'h41);  // fixed delay from lane5 ch31
    route(0, 5, 8'h61, 8'h03);  // from lane3 ch1, control bit set
    route(3, 9, 8'hCA, 8'h03);  // broadcast of lane6 ch10, control bit set
    route(4, 9, 8'hCA, 8'h01);
    route(5, 4, 8'hA7, 8'h05);  // message byte
    route(6, 6, 8'h45, 8'h00);  // disabled
    route(7, 12, 8'hEC, 8'h01); // from lane7 ch12, same slot

    // frame 2
    expect_item(2, 1, 7, 0, 0, 1, pat(1, 2, 0), "R4 gap 1 next frame");
    expect_item(2, 2, 7, 0, 1, 1, pat(1, 1, 30), "R4 wrapped gap 4");
    expect_item(2, 3, 7, 0, 2, 1, pat(2, 0, 0), "R1 R4 gap 3 same frame");
    expect_item(2, 4, 0, 1, 0, 0, 1, "R9 lane0 ch5 control bit");
    expect_item(2, 4, 7, 0, 5, 1, 8'hA7, "R3 message byte");
    expect_item(2, 5, 7, 0, 0, 1, pat(2, 3, 1), "R2 routed byte");
    expect_item(2, 6, 7, 0, 6, 0, 0, "R6 channel disabled");
    expect_item(2, 8, 3, 1, 0, 0, 1, "R9 lane3 ch9 control bit");
    expect_item(2, 8, 4, 1, 0, 0, 0, "R9 lane4 ch9 control bit");
    expect_item(2, 9, 7, 0, 3, 1, pat(1, 6, 10), "R2 broadcast lane3");
    expect_item(2, 9, 7, 0, 4, 1, pat(1, 6, 10), "R2 broadcast lane4");
    expect_item(2, 12, 7, 0, 7, 1, pat(1, 7, 12), "R4 gap 0");
    // frame 3
    expect_item(3, 0, 7, 0, 2, 1, pat(1, 5, 31), "R5 fixed delay ch31 to ch0");
    expect_item(3, 1, 7, 0, 1, 1, pat(1, 1, 31), "R4 wrapped gap 2");
    expect_item(3, 4, 7, 0, 5, 1, 8'hA7, "R3 message repeats");
    expect_item(3, 7, 7, 0, 2, 1, pat(1, 0, 3), "R5 fixed delay");
    // frame 4: global message
    expect_item(4, 5, 7, 0, 0, 1, 8'h61, "R7 forced message");
    expect_item(4, 6, 7, 0, 6, 1, 8'h45, "R7 forced enable");
    // frame 5: drive disabled
    expect_item(5, 4, 7, 0, 5, 0, 0, "R8 drive off lane5");
    expect_item(5, 5, 7, 0, 0, 0, 0, "R8 drive off lane0");
    // frame 6
    expect_item(6, 4, 7, 0, 5, 1, 8'h3C, "R3 rewritten message");
    expect_item(6, 5, 7, 0, 0, 1, pat(6, 3, 1), "R2 routing after override");
    expect_item(6, 6, 7, 0, 6, 0, 0, "R6 disabled after override");
    expect_item(6, 7, 7, 0, 2, 1, pat(4, 0, 3), "R5 fixed delay later frame");

    for (int f = 0; f < 4; f++) run_frame();
    msg_all = 1'b1;
    run_frame();
    msg_all = 1'b0;
    drive_en = 1'b0;
    cm_write(1'b0, 5, 4, 8'h3C);
    run_frame();
    drive_en = 1'b1;
    run_frame();

    while (qk.size() > 0) begin
      check(1'b0, {qt[0], " never observed"}, 0, qk[0]);
      void'(qk.pop_front()); void'(qt.pop_front());
    end
    done = 1;
    summary();
    $finish;
  end
endmodule